// File: doc/BRIEF.md
# Serial Flash DMA Burst Engine

This block is the bulk-transfer half of a serial flash port. Software first issues the flash opcode, address and dummy phases through other logic. It then programs a memory start address and a length word, which also carries the lane code for the data phase, and writes a trigger whose value selects the direction. The engine moves the requested number of bytes between the flash byte streams and a 32-bit memory request port. On the last byte it sets a pending flag, and that flag drives an interrupt when the global enable bit is set.

Each direction has its own limit on how many bytes one trigger may move. A longer buffer is moved as consecutive bursts, with address and length reprogrammed before each trigger. A length above the limit for the chosen direction is cut to that limit, and a sticky error flag is raised. Bytes are packed little-endian. The byte at the programmed address lands in the byte lane selected by its two low address bits, and the following bytes fill the higher lanes in turn.

Top module: `flash_dma_engine`

## Requirements
- R1: After reset, irq is low, fl_rx_ready, fl_tx_valid and mem_req_valid are low, and the pending (0x20) and status (0x40) registers read zero.
- R2: Writing 0 to the trigger register (0x18) starts an inbound burst. Each accepted fl_rx byte k goes to address start+k, in lane (start+k) mod 4 of a write at the word-aligned address. mem_req_be marks only the bytes collected. One write is issued per word touched, and the first and last words may be partial.
- R3: Writing 1 to the trigger starts an outbound burst. The engine reads word-aligned words and presents on fl_tx_data the bytes from the programmed address upward, in ascending address order, with one read per word touched.
- R4: Back-pressure: while mem_req_valid is high and mem_req_ready low, the request and its address, data and byte enables stay unchanged. While fl_tx_valid is high and fl_tx_ready low, fl_tx_data stays unchanged. fl_rx_ready stays low while a write is waiting.
- R5: A length above 2080 (inbound) or 520 (outbound) moves exactly that limit and sets the sticky error flag, bit 1 of 0x20. A length equal to the limit does not set it. Writing 1 to bit 1 clears the flag.
- R6: When a burst ends, bit 0 of 0x20 is set. Writing 1 to bit 0 clears it. irq equals that bit gated by the enable in bit 20 of 0x00.
- R7: Status register 0x40 reads bit 3 = engine busy, bit 2 = inbound active and bit 1 = outbound active.
- R8: A trigger write while a burst is active is ignored: no second burst starts and the active one completes unchanged.
- R9: A length of zero sets the pending bit in the cycle after the trigger and makes no memory request.
- R10: The length register (0x24) holds the byte count in bits 11:0 and the lane code in bits 29:28, and reads back as written. The lane code drives fl_lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| irq | output | 1 | Completion interrupt |
| fl_lanes | output | 2 | Lane code for the data phase |
| fl_rx_valid | input | 1 | Inbound flash byte valid |
| fl_rx_ready | output | 1 | Engine accepts inbound byte |
| fl_rx_data | input | 8 | Inbound flash byte |
| fl_tx_valid | output | 1 | Outbound flash byte valid |
| fl_tx_ready | input | 1 | Flash side accepts outbound byte |
| fl_tx_data | output | 8 | Outbound flash byte |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Word-aligned byte address |
| mem_req_wdata | output | 32 | Write data, little-endian lanes |
| mem_req_be | output | 4 | Byte enables |
| mem_rsp_valid | input | 1 | Read data valid, one per read |
| mem_rsp_data | input | 32 | Read data |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses, a 12-bit length field and limits of 2080 bytes inbound and 520 bytes outbound. With these values both clamps fire at their real thresholds, and a run still fits easily in the cycle budget. The 12-bit field can hold requests well past either limit, so the clamp path is reached from ordinary register writes. Stall patterns on the memory ready and flash ready lines exercise back-pressure at unaligned starts and at partial first and last words.

// File: rtl/flash_dma_pkg.sv
package flash_dma_pkg;
  localparam logic [7:0] OFF_CFG  = 8'h00;
  localparam logic [7:0] OFF_TRIG = 8'h18;
  localparam logic [7:0] OFF_ADDR = 8'h1C;
  localparam logic [7:0] OFF_PEND = 8'h20;
  localparam logic [7:0] OFF_LEN  = 8'h24;
  localparam logic [7:0] OFF_STAT = 8'h40;
  localparam int IE_BIT   = 20;
  localparam int LANE_LSB = 28;

  typedef enum logic {
    DIR_TO_MEM   = 1'b0,
    DIR_TO_FLASH = 1'b1
  } dma_dir_e;
endpackage

// File: rtl/flash_dma_regs.sv
module flash_dma_regs
  import flash_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              eng_busy,
  input  logic              rx_act,
  input  logic              tx_act,
  input  logic              done,
  input  logic              clamp_err,
  output logic              trig,
  output dma_dir_e          trig_dir,
  output logic [ADDR_W-1:0] base_addr,
  output logic [LEN_W-1:0]  len_req,
  output logic [1:0]        lanes,
  output logic              irq
);
  logic              ie_q;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic [1:0]        lanes_q;
  logic              pend_q;
  logic              err_q;
  logic              unused_wd;

  assign unused_wd = ^reg_wdata;

  wire wr_cfg  = reg_wr && (reg_addr == OFF_CFG);
  wire wr_addr = reg_wr && (reg_addr == OFF_ADDR);
  wire wr_len  = reg_wr && (reg_addr == OFF_LEN);
  wire wr_pend = reg_wr && (reg_addr == OFF_PEND);

  assign trig     = reg_wr && (reg_addr == OFF_TRIG) && !eng_busy;
  assign trig_dir = dma_dir_e'(reg_wdata[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q    <= 1'b0;
      base_q  <= '0;
      len_q   <= '0;
      lanes_q <= 2'b00;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (wr_cfg)  ie_q <= reg_wdata[IE_BIT];
      if (wr_addr) base_q <= reg_wdata[ADDR_W-1:0];
      if (wr_len) begin
        len_q   <= reg_wdata[LEN_W-1:0];
        lanes_q <= reg_wdata[LANE_LSB+1:LANE_LSB];
      end
      if (done)                         pend_q <= 1'b1;
      else if (wr_pend && reg_wdata[0]) pend_q <= 1'b0;
      if (clamp_err)                    err_q <= 1'b1;
      else if (wr_pend && reg_wdata[1]) err_q <= 1'b0;
    end
  end

  assign base_addr = base_q;
  assign len_req   = len_q;
  assign lanes     = lanes_q;
  assign irq       = pend_q && ie_q;

  always_comb begin
    reg_rdata = 32'h0;
    case (reg_addr)
      OFF_CFG:  reg_rdata[IE_BIT] = ie_q;
      OFF_ADDR: reg_rdata = 32'(base_q);
      OFF_LEN:  reg_rdata = 32'(len_q) | (32'(lanes_q) << LANE_LSB);
      OFF_PEND: reg_rdata = {30'h0, err_q, pend_q};
      OFF_STAT: reg_rdata = {28'h0, eng_busy, rx_act, tx_act, 1'b0};
      default:  reg_rdata = 32'h0;
    endcase
  end

  // R6
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> pend_q);

  // R6
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && reg_wdata[0] && !done) |=> !pend_q);

  // R5
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr_pend && reg_wdata[1])) |=> err_q);
endmodule

// File: rtl/flash_dma_in.sv
module flash_dma_in #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [31:0]       req_wdata,
  output logic [3:0]        req_be,
  output logic              busy,
  output logic              done
);
  localparam int WORDS_W = ADDR_W - 2;
  localparam int LANES   = 4;

  logic [ADDR_W-1:0]  cur_q;
  logic [LEN_W-1:0]   left_q;
  logic [WORDS_W-1:0] word_q;
  logic [3:0]         be_q;
  logic               pend_q;
  logic               busy_q;
  logic               done_q;
  logic [31:0]        wbuf;

  assign rx_ready = busy_q && !pend_q && (left_q != '0);

  wire take   = rx_valid && rx_ready;
  wire last_b = (cur_q[1:0] == 2'd3) || (left_q == LEN_W'(1));
  wire drain  = pend_q && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      left_q <= '0;
      word_q <= '0;
      be_q   <= 4'h0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        cur_q  <= start_addr;
        left_q <= start_len;
        pend_q <= 1'b0;
        be_q   <= 4'h0;
      end else begin
        if (take) begin
          cur_q  <= cur_q + 1'b1;
          left_q <= left_q - 1'b1;
          word_q <= cur_q[ADDR_W-1:2];
          be_q[cur_q[1:0]] <= 1'b1;
          if (last_b) pend_q <= 1'b1;
        end
        if (drain) begin
          pend_q <= 1'b0;
          be_q   <= 4'h0;
          if (left_q == '0) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                byte_q <= 8'h00;
      else if (start || drain)                   byte_q <= 8'h00;
      else if (take && (cur_q[1:0] == 2'(g)))    byte_q <= rx_data;
    end
    assign wbuf[8*g +: 8] = byte_q;
  end

  assign req_valid = pend_q;
  assign req_addr  = {word_q, 2'b00};
  assign req_wdata = wbuf;
  assign req_be    = be_q;
  assign busy      = busy_q;
  assign done      = done_q;

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                   && $stable(req_wdata) && $stable(req_be)));

  // R2
  wr_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_be != 4'h0));

  // R4
  rx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !rx_ready);
endmodule

// File: rtl/flash_dma_out.sv
module flash_dma_out #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_data,
  output logic              busy,
  output logic              done
);
  logic [ADDR_W-1:0] cur_q;
  logic [LEN_W-1:0]  left_q;
  logic [31:0]       word_q;
  logic              rd_q;
  logic              wait_q;
  logic              have_q;
  logic              busy_q;
  logic              done_q;

  wire give = have_q && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      left_q <= '0;
      word_q <= 32'h0;
      rd_q   <= 1'b0;
      wait_q <= 1'b0;
      have_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        cur_q  <= start_addr;
        left_q <= start_len;
        rd_q   <= 1'b1;
        wait_q <= 1'b0;
        have_q <= 1'b0;
      end else begin
        if (rd_q && req_ready) begin
          rd_q   <= 1'b0;
          wait_q <= 1'b1;
        end
        if (wait_q && rsp_valid) begin
          word_q <= rsp_data;
          have_q <= 1'b1;
          wait_q <= 1'b0;
        end
        if (give) begin
          cur_q  <= cur_q + 1'b1;
          left_q <= left_q - 1'b1;
          if (left_q == LEN_W'(1)) begin
            have_q <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else if (cur_q[1:0] == 2'd3) begin
            have_q <= 1'b0;
            rd_q   <= 1'b1;
          end
        end
      end
    end
  end

  assign tx_valid  = have_q;
  assign tx_data   = word_q[{cur_q[1:0], 3'b000} +: 8];
  assign req_valid = rd_q;
  assign req_addr  = {cur_q[ADDR_W-1:2], 2'b00};
  assign busy      = busy_q;
  assign done      = done_q;

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R3
  one_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_q, wait_q, have_q}));
endmodule

// File: rtl/flash_dma_engine.sv
module flash_dma_engine
  import flash_dma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 12,
  parameter int MAX_IN  = 2080,
  parameter int MAX_OUT = 520
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic [1:0]        fl_lanes,
  input  logic              fl_rx_valid,
  output logic              fl_rx_ready,
  input  logic [7:0]        fl_rx_data,
  output logic              fl_tx_valid,
  input  logic              fl_tx_ready,
  output logic [7:0]        fl_tx_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  output logic [3:0]        mem_req_be,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data
);
  localparam logic [LEN_W-1:0] LIM_IN  = LEN_W'(MAX_IN);
  localparam logic [LEN_W-1:0] LIM_OUT = LEN_W'(MAX_OUT);

  logic              trig;
  dma_dir_e          trig_dir;
  logic [ADDR_W-1:0] base_addr;
  logic [LEN_W-1:0]  len_req;
  logic              in_busy, out_busy, in_done, out_done;
  logic              in_req_v, out_req_v;
  logic [ADDR_W-1:0] in_req_a, out_req_a;
  logic [31:0]       in_req_d;
  logic [3:0]        in_req_be;

  wire              eng_busy  = in_busy || out_busy;
  wire [LEN_W-1:0]  limit     = (trig_dir == DIR_TO_FLASH) ? LIM_OUT : LIM_IN;
  wire              over      = len_req > limit;
  wire [LEN_W-1:0]  eff_len   = over ? limit : len_req;
  wire              zero_len  = trig && (len_req == '0);
  wire              clamp_err = trig && over;
  wire              go_in     = trig && !zero_len && (trig_dir == DIR_TO_MEM);
  wire              go_out    = trig && !zero_len && (trig_dir == DIR_TO_FLASH);
  wire              done      = in_done || out_done || zero_len;

  flash_dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .eng_busy  (eng_busy),
    .rx_act    (in_busy),
    .tx_act    (out_busy),
    .done      (done),
    .clamp_err (clamp_err),
    .trig      (trig),
    .trig_dir  (trig_dir),
    .base_addr (base_addr),
    .len_req   (len_req),
    .lanes     (fl_lanes),
    .irq       (irq)
  );

  flash_dma_in #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_in (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (go_in),
    .start_addr (base_addr),
    .start_len  (eff_len),
    .rx_valid   (fl_rx_valid),
    .rx_ready   (fl_rx_ready),
    .rx_data    (fl_rx_data),
    .req_valid  (in_req_v),
    .req_ready  (mem_req_ready),
    .req_addr   (in_req_a),
    .req_wdata  (in_req_d),
    .req_be     (in_req_be),
    .busy       (in_busy),
    .done       (in_done)
  );

  flash_dma_out #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (go_out),
    .start_addr (base_addr),
    .start_len  (eff_len),
    .tx_valid   (fl_tx_valid),
    .tx_ready   (fl_tx_ready),
    .tx_data    (fl_tx_data),
    .req_valid  (out_req_v),
    .req_ready  (mem_req_ready),
    .req_addr   (out_req_a),
    .rsp_valid  (mem_rsp_valid),
    .rsp_data   (mem_rsp_data),
    .busy       (out_busy),
    .done       (out_done)
  );

  assign mem_req_valid = in_req_v || out_req_v;
  assign mem_req_write = in_req_v;
  assign mem_req_addr  = in_req_v ? in_req_a  : out_req_a;
  assign mem_req_wdata = in_req_v ? in_req_d  : 32'h0;
  assign mem_req_be    = in_req_v ? in_req_be : 4'hF;

  // Checker state: bytes moved in the current burst.
  logic [LEN_W-1:0] seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   seen_q <= '0;
    else if (go_in || go_out)                     seen_q <= '0;
    else if ((fl_rx_valid && fl_rx_ready) || (fl_tx_valid && fl_tx_ready))
                                                  seen_q <= seen_q + 1'b1;
  end

  // R5
  cap_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q <= LIM_IN);

  // R5
  cap_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_busy |-> (seen_q <= LIM_OUT));

  // R8
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_busy, out_busy}));

  // R9
  zero_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_len |=> !mem_req_valid);
endmodule

// File: tb/flash_dma_engine_test.sv
module flash_dma_engine_test;
  localparam logic [7:0] A_CFG = 8'h00, A_TRIG = 8'h18, A_ADDR = 8'h1C,
                         A_PEND = 8'h20, A_LEN = 8'h24, A_STAT = 8'h40;
  localparam int NV = 8;
  // {dir, stall, addr[11:0], len[11:0]}
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 1'b0, 12'h000, 12'd8},
    {1'b0, 1'b1, 12'h005, 12'd6},
    {1'b0, 1'b1, 12'h003, 12'd1},
    {1'b0, 1'b1, 12'h040, 12'd33},
    {1'b1, 1'b0, 12'h000, 12'd8},
    {1'b1, 1'b1, 12'h006, 12'd7},
    {1'b1, 1'b0, 12'h101, 12'd1},
    {1'b1, 1'b1, 12'h080, 12'd40}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic irq;
  logic [1:0] fl_lanes;
  logic fl_rx_valid = 1'b0, fl_rx_ready;
  logic [7:0] fl_rx_data = 8'h0;
  logic fl_tx_valid, fl_tx_ready = 1'b0;
  logic [7:0] fl_tx_data;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0] mem_req_be;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = 32'h0;

  always #4 clk = ~clk;

  flash_dma_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .fl_lanes(fl_lanes),
    .fl_rx_valid(fl_rx_valid), .fl_rx_ready(fl_rx_ready), .fl_rx_data(fl_rx_data),
    .fl_tx_valid(fl_tx_valid), .fl_tx_ready(fl_tx_ready), .fl_tx_data(fl_tx_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

  int checks = 0, errors = 0;
  logic [7:0] mem_b [8192];
  logic [7:0] cap [4096];
  int rx_idx, rx_cnt, tx_cnt, wr_cnt, rd_cnt, cyc, viol;
  int seed;
  bit rx_en = 1'b0, stall = 1'b0, done_flag = 1'b0;
  bit rx_fire_prev = 1'b0, rd_fire_prev = 1'b0, mhold = 1'b0, thold = 1'b0;
  int rd_a;
  logic [31:0] pa, pd; logic [3:0] pb; logic [7:0] pt;

  function automatic logic [7:0] pat(int k);
    return 8'(k * 7 + seed);
  endfunction

  function automatic int words(int a, int n);
    return ((a + n - 1) >> 2) - (a >> 2) + 1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bus models: all decisions at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rx_fire_prev) begin rx_idx++; rx_cnt++; end
      fl_rx_valid = rx_en;
      fl_rx_data  = pat(rx_idx);
      rx_fire_prev = fl_rx_valid && fl_rx_ready;
      mem_req_ready = !stall || (cyc % 3 != 0);
      fl_tx_ready   = !stall || (cyc % 4 != 1);
      if (thold && (!fl_tx_valid || fl_tx_data !== pt)) viol++;
      if (mhold && (!mem_req_valid || mem_req_addr !== pa ||
                    mem_req_wdata !== pd || mem_req_be !== pb)) viol++;
      thold = fl_tx_valid && !fl_tx_ready; pt = fl_tx_data;
      mhold = mem_req_valid && !mem_req_ready;
      pa = mem_req_addr; pd = mem_req_wdata; pb = mem_req_be;
      if (fl_tx_valid && fl_tx_ready) begin cap[tx_cnt % 4096] = fl_tx_data; tx_cnt++; end
      mem_rsp_valid = 1'b0;
      if (rd_fire_prev) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = {mem_b[rd_a+3], mem_b[rd_a+2], mem_b[rd_a+1], mem_b[rd_a]};
      end
      rd_fire_prev = 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          wr_cnt++;
          for (int b = 0; b < 4; b++)
            if (mem_req_be[b]) mem_b[int'(mem_req_addr[12:0]) + b] = mem_req_wdata[8*b +: 8];
        end else begin
          rd_cnt++;
          rd_fire_prev = 1'b1;
          rd_a = int'(mem_req_addr[12:0]);
        end
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(string req);
    logic [31:0] s;
    int n = 0;
    do begin rd(A_STAT, s); n++; end while (s[3] && n < 20000);
    if (s[3]) chk({req, " timeout"}, 32'h1, 32'h0);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_counts();
    rx_idx = 0; rx_cnt = 0; tx_cnt = 0; wr_cnt = 0; rd_cnt = 0;
  endtask

  task automatic fill(bit inbound);
    for (int j = 0; j < 8192; j++) mem_b[j] = inbound ? 8'hEE : 8'(j * 5 + 1);
  endtask

  initial begin
    logic [31:0] d;
    int bad;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 rx_ready", {31'h0, fl_rx_ready}, 32'h0);
    chk("R1 tx_valid", {31'h0, fl_tx_valid}, 32'h0);
    chk("R1 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
    rst_n = 1'b1;
    rd(A_PEND, d); chk("R1 pending", d, 32'h0);
    rd(A_STAT, d); chk("R1 status", d, 32'h0);
    wr(A_CFG, 32'h1 << 20);

    // Table of bursts (R2 inbound, R3 outbound, R4 under stalls, R6 completion)
    for (int i = 0; i < NV; i++) begin
      bit dir; int a, n;
      dir = VEC[i][25]; stall = VEC[i][24]; a = int'(VEC[i][23:12]); n = int'(VEC[i][11:0]);
      seed = i * 17 + 3;
      fill(!dir);
      clear_counts();
      rx_en = !dir;
      wr(A_ADDR, 32'(a));
      wr(A_LEN, 32'(n));
      wr(A_TRIG, {31'h0, dir});
      wait_idle("R2/R3");
      rx_en = 1'b0;
      bad = 0;
      if (!dir) begin
        for (int k = 0; k < n; k++) if (mem_b[a + k] !== pat(k)) bad++;
        if (a > 0 && mem_b[a - 1] !== 8'hEE) bad++;
        if (mem_b[a + n] !== 8'hEE) bad++;
        chk("R2 packed bytes", 32'(bad), 32'h0);
        chk("R2 write count", 32'(wr_cnt), 32'(words(a, n)));
      end else begin
        for (int k = 0; k < n; k++) if (cap[k] !== mem_b[a + k]) bad++;
        chk("R3 byte order", 32'(bad), 32'h0);
        chk("R3 byte count", 32'(tx_cnt), 32'(n));
        chk("R3 read count", 32'(rd_cnt), 32'(words(a, n)));
      end
      rd(A_PEND, d); chk("R6 pending set", d, 32'h1);
      chk("R6 irq on", {31'h0, irq}, 32'h1);
      wr(A_PEND, 32'h1);
      rd(A_PEND, d); chk("R6 pending cleared", d, 32'h0);
      chk("R6 irq off", {31'h0, irq}, 32'h0);
    end
    stall = 1'b0;
    chk("R4 handshake hold", 32'(viol), 32'h0);

    // R7 / R8: inbound held without data, outbound trigger ignored
    fill(1'b1); clear_counts(); seed = 9;
    wr(A_ADDR, 32'h20); wr(A_LEN, 32'd4); wr(A_TRIG, 32'h0);
    rd(A_STAT, d); chk("R7 inbound status", d, 32'hC);
    wr(A_TRIG, 32'h1);
    repeat (4) @(negedge clk);
    rd(A_STAT, d); chk("R8 status unchanged", d, 32'hC);
    chk("R8 no tx", {31'h0, fl_tx_valid}, 32'h0);
    rx_en = 1'b1;
    wait_idle("R8");
    rx_en = 1'b0;
    chk("R8 reads none", 32'(rd_cnt + tx_cnt), 32'h0);
    chk("R8 one write", 32'(wr_cnt), 32'h1);
    wr(A_PEND, 32'h3);
    wr(A_ADDR, 32'h0); wr(A_LEN, 32'd8); wr(A_TRIG, 32'h1);
    rd(A_STAT, d); chk("R7 outbound status", d, 32'hA);
    wait_idle("R7");
    wr(A_PEND, 32'h3);

    // R5 clamps and exact limits
    fill(1'b1); clear_counts(); seed = 1; rx_en = 1'b1;
    wr(A_ADDR, 32'h0); wr(A_LEN, 32'd2200); wr(A_TRIG, 32'h0);
    wait_idle("R5"); rx_en = 1'b0;
    chk("R5 inbound clamped", 32'(rx_cnt), 32'd2080);
    chk("R5 byte past limit", {24'h0, mem_b[2080]}, 32'hEE);
    rd(A_PEND, d); chk("R5 error flag", d, 32'h3);
    wr(A_PEND, 32'h2);
    rd(A_PEND, d); chk("R5 error cleared", d, 32'h1);
    wr(A_PEND, 32'h1);
    fill(1'b0); clear_counts();
    wr(A_ADDR, 32'h10); wr(A_LEN, 32'd700); wr(A_TRIG, 32'h1);
    wait_idle("R5");
    chk("R5 outbound clamped", 32'(tx_cnt), 32'd520);
    rd(A_PEND, d); chk("R5 error out", d, 32'h3);
    wr(A_PEND, 32'h3); clear_counts();
    wr(A_LEN, 32'd520); wr(A_TRIG, 32'h1);
    wait_idle("R5");
    chk("R5 exact out count", 32'(tx_cnt), 32'd520);
    rd(A_PEND, d); chk("R5 no error at limit", d, 32'h1);
    wr(A_PEND, 32'h3);
    clear_counts(); rx_en = 1'b1;
    wr(A_ADDR, 32'h0); wr(A_LEN, 32'd2080); wr(A_TRIG, 32'h0);
    wait_idle("R5"); rx_en = 1'b0;
    chk("R5 exact in count", 32'(rx_cnt), 32'd2080);
    rd(A_PEND, d); chk("R5 no error at in limit", d, 32'h1);
    wr(A_PEND, 32'h3);

    // R9 zero length
    clear_counts();
    wr(A_LEN, 32'd0); wr(A_TRIG, 32'h0);
    rd(A_PEND, d); chk("R9 pending at once", d, 32'h1);
    repeat (5) @(negedge clk);
    chk("R9 no memory access", 32'(wr_cnt + rd_cnt), 32'h0);
    rd(A_STAT, d); chk("R9 idle", d, 32'h0);

    // R6 enable gating
    wr(A_CFG, 32'h0);
    chk("R6 irq gated", {31'h0, irq}, 32'h0);
    wr(A_CFG, 32'h1 << 20);
    chk("R6 irq enabled", {31'h0, irq}, 32'h1);
    rd(A_CFG, d); chk("R6 cfg readback", d, 32'h0010_0000);
    wr(A_PEND, 32'h1);

    // R10 lane code
    wr(A_LEN, 32'h2000_0123);
    chk("R10 lanes", {30'h0, fl_lanes}, 32'h2);
    rd(A_LEN, d); chk("R10 length readback", d, 32'h2000_0123);
    wr(A_LEN, 32'h1000_0004);
    chk("R10 lanes dual", {30'h0, fl_lanes}, 32'h1);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule